// File: doc/BRIEF.md
# Latching Up/Down Position Counter

This block is one axis of a position-monitoring counter. A quadrature or pulse decoder gives it a count strobe and a direction bit, and the block keeps a wrapping 24-bit position. A holding register takes a snapshot of the position when a selected trigger fires. The host then reads that snapshot as three bytes.

The trigger is chosen by a 3-bit code from five sources:
- the host's read of the high byte;
- an index pulse;
- either of two digital inputs;
- a periodic timer tick.

Each trigger can also return the counter to its reset value, which is zero or mid-scale. A direct reset command does the same thing.

A sticky overflow flag records wrap-around in either direction. Carry and borrow outputs let a second instance, placed in cascade mode, act as the upper half of a 48-bit counter. All trigger inputs are shared between the two instances, so both halves are captured on the same edge.

Top module: `pos_latch_counter`

## Requirements
- R1: On each clock edge where `cnt_strobe` is high (and cascade mode is off), the count moves by one: up when `cnt_dir` is 1, down when `cnt_dir` is 0.
- R2: When the count wraps (maximum to zero going up, zero to maximum going down), `ovf_flag` becomes 1 on the next cycle and stays 1. A one-cycle `ovf_clr` pulse clears it. If a wrap happens in the same cycle as the clear, the flag stays set.
- R3: The latch source code `cfg_src` selects the trigger: 0 is `rd_hi`, 1 is `idx_in`, 2 is `din0`, 3 is `din1`, 4 is `tmr_tick`. Codes 5 to 7 select no trigger. A trigger other than the selected one leaves the snapshot unchanged.
- R4: A trigger loads the snapshot with the count as it stood before that cycle's step. The snapshot bytes come out as `lat_lo` = bits 7:0, `lat_mid` = bits 15:8 and `lat_hi` = bits 23:16. The snapshot holds until the next trigger.
- R5: With `cfg_rst_on_lat` set, the cycle in which a trigger fires loads the reset value into the counter instead of applying any step.
- R6: The reset value is 0 when `cfg_mid_rst` is 0. When it is 1, the reset value has only the most significant bit set (24'h800000).
- R7: `cmd_rst` loads the reset value and takes priority over a step in the same cycle. A trigger in that same cycle still captures the count from before the reset.
- R8: `carry_up` or `borrow_dn` is high, combinationally, during exactly the cycle in which an applied step wraps the counter upward or downward.
- R9: With `cfg_cascade` set, the counter steps up on `casc_up_in` and down on `casc_dn_in`, and ignores `cnt_strobe`. Fed from a lower instance's carry and borrow, the pair behaves as one 48-bit counter.
- R10: `idx_in`, `din0` and `din1` trigger on a rising edge: the input is high in this cycle and was low in the previous cycle. Holding one of them high gives a single capture.
- R11: While `rst_n` is low at a clock edge, the count, the snapshot and the overflow flag are all cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_src | input | 3 | Latch trigger select code |
| cfg_rst_on_lat | input | 1 | Reset the counter whenever a trigger fires |
| cfg_mid_rst | input | 1 | Reset value is mid-scale instead of zero |
| cfg_cascade | input | 1 | Count from the cascade inputs instead of the strobe |
| cnt_strobe | input | 1 | One-cycle count step request |
| cnt_dir | input | 1 | Step direction, 1 = up |
| casc_up_in | input | 1 | Carry from the lower counter |
| casc_dn_in | input | 1 | Borrow from the lower counter |
| cmd_rst | input | 1 | Direct counter reset command |
| rd_hi | input | 1 | Host read of the high byte (software trigger) |
| idx_in | input | 1 | Index input |
| din0 | input | 1 | Digital input 0 |
| din1 | input | 1 | Digital input 1 |
| tmr_tick | input | 1 | Periodic timer pulse |
| ovf_clr | input | 1 | Host read of the overflow flag; clears it |
| lat_lo | output | 8 | Snapshot bits 7:0 |
| lat_mid | output | 8 | Snapshot bits 15:8 |
| lat_hi | output | 8 | Snapshot bits 23:16 |
| ovf_flag | output | 1 | Sticky wrap flag |
| carry_up | output | 1 | Upward wrap in this cycle |
| borrow_dn | output | 1 | Downward wrap in this cycle |

## Verification
The assertions assume the following about the inputs:
- the configuration bits change only while the counter is idle;
- a lower stage never raises carry and borrow together;
- the software-read and timer triggers arrive as single-cycle pulses.

The stimulus drives every input on the falling clock edge. It changes `cfg_src` and the reset options only between operations, never together with a step or a trigger. It fires each trigger for exactly one cycle, except in the held-input case that checks rising-edge behaviour.

The bench uses a 12-bit configuration with 4-bit bytes. This keeps both wrap directions and a full sweep of every trigger against every select code within a short run.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;

   // Trigger select encodings; codes above SRC_TIMER select nothing
   typedef enum logic [2:0] {
      SRC_SWRD  = 3'd0,
      SRC_INDEX = 3'd1,
      SRC_DIN0  = 3'd2,
      SRC_DIN1  = 3'd3,
      SRC_TIMER = 3'd4
   } latch_src_e;

   localparam int unsigned SRC_W = 3;

endpackage

// File: rtl/pcnt_trig_sel.sv
module pcnt_trig_sel
   import pcnt_pkg::*;
#(
   parameter bit EDGE_TRIG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SRC_W-1:0] src,
   input  logic             rd_hi,
   input  logic             idx_in,
   input  logic             din0,
   input  logic             din1,
   input  logic             tmr_tick,
   output logic             fire
);

   localparam int unsigned N_EXT = 3;

   logic [N_EXT-1:0] ext_raw;
   logic [N_EXT-1:0] ext_evt;

   assign ext_raw = {din1, din0, idx_in};

   generate
      if (EDGE_TRIG) begin : g_edge
         logic [N_EXT-1:0] ext_q;

         always_ff @(posedge clk) begin
            if (!rst_n) ext_q <= '0;
            else        ext_q <= ext_raw;
         end

         assign ext_evt = ext_raw & ~ext_q;

         // R10: a level held high yields no event in its second cycle
         p_edge_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
            ext_raw[0] |=> !ext_evt[0]);
      end else begin : g_level
         assign ext_evt = ext_raw;
      end
   endgenerate

   always_comb begin
      unique case (src)
         SRC_SWRD:  fire = rd_hi;
         SRC_INDEX: fire = ext_evt[0];
         SRC_DIN0:  fire = ext_evt[1];
         SRC_DIN1:  fire = ext_evt[2];
         SRC_TIMER: fire = tmr_tick;
         default:   fire = 1'b0;
      endcase
   end

   // R3: unused codes never fire
   p_no_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (src > SRC_TIMER) |-> !fire);

endmodule

// File: rtl/pcnt_core.sv
module pcnt_core #(
   parameter int unsigned CNT_W      = 24,
   parameter bit          CASCADE_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_mid,
   input  logic             cfg_rol,
   input  logic             cfg_cascade,
   input  logic             strobe,
   input  logic             dir_up,
   input  logic             casc_up,
   input  logic             casc_dn,
   input  logic             cmd_rst,
   input  logic             lat_fire,
   input  logic             ovf_clr,
   output logic [CNT_W-1:0] cnt_q,
   output logic             ovf_q,
   output logic             carry_up,
   output logic             borrow_dn
);

   localparam logic [CNT_W-1:0] MAX_V = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] MID_V = {1'b1, {(CNT_W-1){1'b0}}};

   logic             step;
   logic             up;
   logic             clear;
   logic             apply;
   logic [CNT_W-1:0] rst_val;
   logic [CNT_W-1:0] cnt_d;
   logic             wrap;

   generate
      if (CASCADE_EN) begin : g_casc
         assign step = cfg_cascade ? (casc_up ^ casc_dn) : strobe;
         assign up   = cfg_cascade ? casc_up : dir_up;
      end else begin : g_plain
         logic unused_casc;
         assign unused_casc = cfg_cascade ^ casc_up ^ casc_dn;
         assign step = strobe;
         assign up   = dir_up;
      end
   endgenerate

   assign rst_val   = cfg_mid ? MID_V : '0;
   assign clear     = cmd_rst | (lat_fire & cfg_rol);
   assign apply     = step & ~clear;
   assign carry_up  = apply & up & (cnt_q == MAX_V);
   assign borrow_dn = apply & ~up & (cnt_q == '0);
   assign wrap      = carry_up | borrow_dn;

   always_comb begin
      if (clear)      cnt_d = rst_val;
      else if (apply) cnt_d = up ? cnt_q + 1'b1 : cnt_q - 1'b1;
      else            cnt_d = cnt_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ovf_q <= 1'b0;
      end else begin
         cnt_q <= cnt_d;
         if (wrap)         ovf_q <= 1'b1;
         else if (ovf_clr) ovf_q <= 1'b0;
      end
   end

   p_wrap_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(carry_up && borrow_dn));

   p_wrap_sets_ovf_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> ovf_q);

   p_ovf_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_clr && !wrap) |=> !ovf_q);

   p_cmd_rst_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_rst |=> (cnt_q == ($past(cfg_mid) ? MID_V : '0)));

   p_step_up_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (apply && up) |=> (cnt_q == $past(cnt_q) + 1'b1));

   p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !clear) |=> $stable(cnt_q));

endmodule

// File: rtl/pcnt_snap.sv
module pcnt_snap #(
   parameter int unsigned CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lat_fire,
   input  logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] snap_q
);

   always_ff @(posedge clk) begin
      if (!rst_n)        snap_q <= '0;
      else if (lat_fire) snap_q <= cnt_q;
   end

   p_snap_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !lat_fire |=> $stable(snap_q));

endmodule

// File: rtl/pos_latch_counter.sv
module pos_latch_counter
   import pcnt_pkg::*;
#(
   parameter int unsigned CNT_W      = 24,
   parameter int unsigned BYTE_W     = 8,
   parameter bit          CASCADE_EN = 1'b1,
   parameter bit          EDGE_TRIG  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SRC_W-1:0]  cfg_src,
   input  logic              cfg_rst_on_lat,
   input  logic              cfg_mid_rst,
   input  logic              cfg_cascade,
   input  logic              cnt_strobe,
   input  logic              cnt_dir,
   input  logic              casc_up_in,
   input  logic              casc_dn_in,
   input  logic              cmd_rst,
   input  logic              rd_hi,
   input  logic              idx_in,
   input  logic              din0,
   input  logic              din1,
   input  logic              tmr_tick,
   input  logic              ovf_clr,
   output logic [BYTE_W-1:0] lat_lo,
   output logic [BYTE_W-1:0] lat_mid,
   output logic [BYTE_W-1:0] lat_hi,
   output logic              ovf_flag,
   output logic              carry_up,
   output logic              borrow_dn
);

   localparam int unsigned N_BYTES = CNT_W / BYTE_W;

   generate
      if (CNT_W != N_BYTES * BYTE_W || N_BYTES != 3) begin : g_bad_width
         $error("pos_latch_counter: CNT_W must be three whole bytes");
      end
   endgenerate

   logic             fire;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] snap_q;

   pcnt_trig_sel #(.EDGE_TRIG(EDGE_TRIG)) u_trig (
      .clk      (clk),
      .rst_n    (rst_n),
      .src      (cfg_src),
      .rd_hi    (rd_hi),
      .idx_in   (idx_in),
      .din0     (din0),
      .din1     (din1),
      .tmr_tick (tmr_tick),
      .fire     (fire)
   );

   pcnt_core #(.CNT_W(CNT_W), .CASCADE_EN(CASCADE_EN)) u_core (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_mid     (cfg_mid_rst),
      .cfg_rol     (cfg_rst_on_lat),
      .cfg_cascade (cfg_cascade),
      .strobe      (cnt_strobe),
      .dir_up      (cnt_dir),
      .casc_up     (casc_up_in),
      .casc_dn     (casc_dn_in),
      .cmd_rst     (cmd_rst),
      .lat_fire    (fire),
      .ovf_clr     (ovf_clr),
      .cnt_q       (cnt_q),
      .ovf_q       (ovf_flag),
      .carry_up    (carry_up),
      .borrow_dn   (borrow_dn)
   );

   pcnt_snap #(.CNT_W(CNT_W)) u_snap (
      .clk      (clk),
      .rst_n    (rst_n),
      .lat_fire (fire),
      .cnt_q    (cnt_q),
      .snap_q   (snap_q)
   );

   assign lat_lo  = snap_q[BYTE_W-1:0];
   assign lat_mid = snap_q[2*BYTE_W-1:BYTE_W];
   assign lat_hi  = snap_q[3*BYTE_W-1:2*BYTE_W];

   // R4: capture takes the count from before this cycle's step or reset
   p_capture_pre_r4: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> (snap_q == $past(cnt_q)));

   // R5: reset-on-latch puts the counter at zero or mid-scale
   p_rol_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && cfg_rst_on_lat) |=> (cnt_q == {$past(cfg_mid_rst), {(CNT_W-1){1'b0}}}));

endmodule

// File: tb/pos_latch_counter_tb.sv
module pos_latch_counter_tb;
   localparam int W    = 12;
   localparam int B    = 4;
   localparam int MAXV = (1 << W) - 1;
   localparam int MIDV = 1 << (W - 1);

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic       rst_n = 1'b0;
   logic [2:0] cfg_src = 3'd0;
   logic       cfg_rol = 1'b0, cfg_mid = 1'b0;
   logic       strobe = 1'b0, dir = 1'b1, cmd_rst = 1'b0;
   logic       rd_hi = 1'b0, idx = 1'b0, d0 = 1'b0, d1 = 1'b0, tmr = 1'b0;
   logic       ovf_clr = 1'b0;

   logic [B-1:0] lo_l, lo_m, lo_h, hi_l, hi_m, hi_h;
   logic         lo_ovf, hi_ovf, lo_cy, lo_bw, hi_cy, hi_bw;

   int n_cmp = 0, n_bad = 0;
   int m_lo = 0, m_hi = 0;
   bit done = 1'b0;

   pos_latch_counter #(.CNT_W(W), .BYTE_W(B)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_src(cfg_src), .cfg_rst_on_lat(cfg_rol),
      .cfg_mid_rst(cfg_mid), .cfg_cascade(1'b0), .cnt_strobe(strobe),
      .cnt_dir(dir), .casc_up_in(1'b0), .casc_dn_in(1'b0), .cmd_rst(cmd_rst),
      .rd_hi(rd_hi), .idx_in(idx), .din0(d0), .din1(d1), .tmr_tick(tmr),
      .ovf_clr(ovf_clr), .lat_lo(lo_l), .lat_mid(lo_m), .lat_hi(lo_h),
      .ovf_flag(lo_ovf), .carry_up(lo_cy), .borrow_dn(lo_bw));

   pos_latch_counter #(.CNT_W(W), .BYTE_W(B)) u_hi (
      .clk(clk), .rst_n(rst_n), .cfg_src(cfg_src), .cfg_rst_on_lat(1'b0),
      .cfg_mid_rst(1'b0), .cfg_cascade(1'b1), .cnt_strobe(1'b0),
      .cnt_dir(1'b1), .casc_up_in(lo_cy), .casc_dn_in(lo_bw), .cmd_rst(1'b0),
      .rd_hi(rd_hi), .idx_in(idx), .din0(d0), .din1(d1), .tmr_tick(tmr),
      .ovf_clr(ovf_clr), .lat_lo(hi_l), .lat_mid(hi_m), .lat_hi(hi_h),
      .ovf_flag(hi_ovf), .carry_up(hi_cy), .borrow_dn(hi_bw));

   function automatic int snap_lo();
      return int'({lo_h, lo_m, lo_l});
   endfunction

   function automatic int snap_hi();
      return int'({hi_h, hi_m, hi_l});
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // One clock per step; the bench model tracks both halves
   task automatic steps(input int n, input bit up);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         strobe = 1'b1;
         dir = up;
         if (up) begin
            if (m_lo == MAXV) begin m_lo = 0; m_hi = (m_hi + 1) & MAXV; end
            else m_lo++;
         end else begin
            if (m_lo == 0) begin m_lo = MAXV; m_hi = (m_hi - 1) & MAXV; end
            else m_lo--;
         end
      end
      @(negedge clk);
      strobe = 1'b0;
   endtask

   task automatic do_rst(input bit mid);
      @(negedge clk);
      cfg_mid = mid;
      cmd_rst = 1'b1;
      m_lo = mid ? MIDV : 0;
      @(negedge clk);
      cmd_rst = 1'b0;
   endtask

   // Software-read capture with cfg_src = 0
   task automatic sw_read();
      @(negedge clk);
      rd_hi = 1'b1;
      if (cfg_rol) m_lo = cfg_mid ? MIDV : 0;
      @(negedge clk);
      rd_hi = 1'b0;
   endtask

   task automatic pulse_trig(input int k);
      @(negedge clk);
      case (k)
         0: rd_hi = 1'b1;
         1: idx = 1'b1;
         2: d0 = 1'b1;
         3: d1 = 1'b1;
         default: tmr = 1'b1;
      endcase
      @(negedge clk);
      {rd_hi, idx, d0, d1, tmr} = '0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      int exp_snap;
      int v;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11 snapshot", snap_lo(), 0);
      chk("R11 ovf", int'(lo_ovf), 0);

      steps(5, 1'b1);
      sw_read();
      chk("R1 up count", snap_lo(), 5);
      chk("R4 byte order", int'(lo_l), 5);
      steps(2, 1'b0);
      sw_read();
      chk("R1 down count", snap_lo(), 3);

      do_rst(1'b0);
      sw_read();
      chk("R7 reset to zero", snap_lo(), 0);

      @(negedge clk);
      strobe = 1'b1;
      dir = 1'b0;
      #1;
      chk("R8 borrow", int'(lo_bw), 1);
      chk("R8 no carry", int'(lo_cy), 0);
      m_lo = MAXV;
      m_hi = MAXV;
      @(negedge clk);
      strobe = 1'b0;
      chk("R2 ovf set on down wrap", int'(lo_ovf), 1);
      sw_read();
      chk("R2 wrapped value", snap_lo(), MAXV);
      chk("R9 cascade borrow", snap_hi(), m_hi);

      @(negedge clk);
      ovf_clr = 1'b1;
      @(negedge clk);
      ovf_clr = 1'b0;
      chk("R2 ovf cleared", int'(lo_ovf), 0);

      do_rst(1'b1);
      sw_read();
      chk("R6 mid reset", snap_lo(), MIDV);
      chk("R6 byte hi", int'(lo_h), MIDV >> (2 * B));
      steps(MAXV - MIDV, 1'b1);
      @(negedge clk);
      strobe = 1'b1;
      dir = 1'b1;
      #1;
      chk("R8 carry", int'(lo_cy), 1);
      m_lo = 0;
      m_hi = 0;
      @(negedge clk);
      strobe = 1'b0;
      chk("R2 ovf set on up wrap", int'(lo_ovf), 1);
      chk("R9 high half wraps", int'(hi_ovf), 1);
      sw_read();
      chk("R9 48-bit low", snap_lo(), 0);
      chk("R9 48-bit high", snap_hi(), 0);

      // capture and step in the same cycle: capture sees the old count
      @(negedge clk);
      rd_hi = 1'b1;
      strobe = 1'b1;
      dir = 1'b1;
      @(negedge clk);
      rd_hi = 1'b0;
      strobe = 1'b0;
      chk("R4 pre-count capture", snap_lo(), 0);
      m_lo = 1;
      sw_read();
      chk("R4 step still applied", snap_lo(), 1);

      // reset command together with a step and a capture
      steps(4, 1'b1);
      @(negedge clk);
      cfg_mid = 1'b0;
      cmd_rst = 1'b1;
      strobe = 1'b1;
      rd_hi = 1'b1;
      @(negedge clk);
      {cmd_rst, strobe, rd_hi} = '0;
      chk("R7 capture before reset", snap_lo(), 5);
      m_lo = 0;
      sw_read();
      chk("R7 reset beats step", snap_lo(), 0);

      // reset on latch
      @(negedge clk);
      cfg_rol = 1'b1;
      steps(7, 1'b1);
      sw_read();
      chk("R5 snapshot before reset", snap_lo(), 7);
      steps(3, 1'b1);
      sw_read();
      chk("R5 counter restarted", snap_lo(), 3);
      @(negedge clk);
      cfg_mid = 1'b1;
      sw_read();
      sw_read();
      chk("R5 mid restart", snap_lo(), MIDV);
      @(negedge clk);
      cfg_rol = 1'b0;
      cfg_mid = 1'b0;

      // sweep every select code against every trigger
      exp_snap = snap_lo();
      for (int s = 0; s < 8; s++) begin
         for (int k = 0; k < 5; k++) begin
            do_rst(1'b0);
            @(negedge clk);
            cfg_src = 3'(s);
            v = 8 * s + k + 1;
            steps(v, 1'b1);
            pulse_trig(k);
            if (s == k) exp_snap = v;
            chk($sformatf("R3 src %0d trig %0d", s, k), snap_lo(), exp_snap);
            @(negedge clk);
            cfg_src = 3'd0;
         end
      end

      // held digital input captures only once
      do_rst(1'b0);
      @(negedge clk);
      cfg_src = 3'd2;
      @(negedge clk);
      d0 = 1'b1;
      strobe = 1'b1;
      dir = 1'b1;
      repeat (3) @(negedge clk);
      strobe = 1'b0;
      d0 = 1'b0;
      chk("R10 single capture on held input", snap_lo(), 0);
      @(negedge clk);
      cfg_src = 3'd0;

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule